// File: doc/BRIEF.md
# FIFO Flag Offset Registers

This block holds the two threshold offsets that a FIFO's flag logic compares against its fill level. One offset sets how close to empty the almost-empty flag switches, and the other sets how close to full the almost-full flag switches. The two are fully independent, and each can be any value that fits in the address width. Both are driven out continuously to the flag comparators. The comparators and the FIFO storage sit outside this block.

A master reset loads both offsets with one of eight built-in defaults. The same reset fixes the programming method for the rest of the session: serial loading (one bit per write clock) or parallel loading (one whole offset per write clock from the data input). The offsets can be read back in parallel on the read clock with either method. A partial reset only rewinds the access sequence back to the almost-empty register. It keeps the offsets and the chosen method, so a FIFO can be restarted mid-operation without being reprogrammed.

The register paths are plain strobed accesses, not streams. A strobe is accepted on the edge where it is sampled, and the block never applies back-pressure. A readback word appears on `rd_data` one read clock after the read strobe, together with a one-cycle `rd_valid` pulse. The sink must take it in that cycle. The master and partial resets are sampled by both clocks and must be held across at least one edge of each. Loading and readback are not meant to overlap.

Top module: `flag_offset_regs`

## Requirements
- R1: While `mrst` is high, both offsets take the default for index k = {`ld`, `def_sel[1]`, `def_sel[0]`}, equal to 2^(k+3)-1 truncated to AW bits. The values are 7, 15, 31, 63, 127, 255, 511 and 1023 for k = 0..7.
- R2: The level of `ld` at the last write-clock edge of master reset selects the method: high gives parallel loading, low gives serial loading. Strobes for the method that was not selected leave both offsets unchanged.
- R3: In parallel mode, each write-clock edge with `wr_en` and `ld` both high loads `wr_data` into one offset. The target alternates almost-empty, almost-full, almost-empty, and so on, starting with almost-empty after master reset. `wr_en` without `ld` does nothing.
- R4: In serial mode, each write-clock edge with `ser_en` and `ld` both high writes `ser_in` into the next bit position, in place. The order is almost-empty bit 0 up to bit AW-1, then almost-full bit 0 up to bit AW-1. After 2*AW bits the position wraps to almost-empty bit 0.
- R5: Each read-clock edge with `rd_en` and `ld` both high places the next offset on `rd_data` one cycle later and pulses `rd_valid` high for that cycle. The order alternates almost-empty, almost-full, starting with almost-empty. This works in both methods. `rd_valid` is low in every other cycle.
- R6: A partial reset (`prst` high) keeps both offset values and the programming method. It returns the parallel write target, the read target and the serial bit position to the start of the almost-empty register.
- R7: A load aimed at one offset leaves the other offset unchanged.
- R8: During master reset all load and read strobes are ignored, and `rd_valid` stays low.
- R9: On a write-clock edge where `prst` is high, load strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; all loading happens on its rising edge |
| rclk | input | 1 | Read clock; readback happens on its rising edge |
| mrst | input | 1 | Master reset, active high, synchronous to each clock |
| prst | input | 1 | Partial reset, active high, synchronous to each clock |
| def_sel | input | 2 | Low two bits of the default index, sampled during master reset |
| ld | input | 1 | Load strobe; top bit of the default index and method select during master reset |
| wr_en | input | 1 | Parallel load enable |
| wr_data | input | AW | Parallel load value |
| ser_en | input | 1 | Serial load enable |
| ser_in | input | 1 | Serial data bit |
| rd_en | input | 1 | Readback enable |
| rd_data | output | AW | Readback value, held until the next read |
| rd_valid | output | 1 | High for one read cycle when `rd_data` carries a new read |
| ae_offset | output | AW | Almost-empty offset to the flag comparator |
| af_offset | output | AW | Almost-full offset to the flag comparator |

## Verification
The assertions check several things on every cycle. Outside reset the method stays fixed. An edge with no strobe for the active method, or with a partial reset, leaves both offsets unchanged. Each parallel load flips the write target. The serial position stays within its 2*AW range. `rd_valid` follows the read strobe exactly one cycle later. Only the bench scenarios can show the actual values: the eight defaults, the alternating order of parallel loads and readbacks, the LSB-first bit order and wrap of serial loading, and the rewinding of the sequence after a partial reset while the offsets survive.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;

  // Which offset register a sequenced access targets next.
  typedef enum logic {
    TGT_AE = 1'b0,
    TGT_AF = 1'b1
  } ofs_tgt_e;

  // Default offset for a three-bit reset index: 2^(idx+3) - 1.
  function automatic int unsigned default_offset(input logic [2:0] idx);
    int unsigned sh;
    sh = int'(idx) + 3;
    return (32'd1 << sh) - 32'd1;
  endfunction

  function automatic ofs_tgt_e next_tgt(input ofs_tgt_e t);
    return (t == TGT_AE) ? TGT_AF : TGT_AE;
  endfunction

endpackage

// File: rtl/ofs_load_side.sv
`timescale 1ns/1ps
module ofs_load_side #(
  parameter int AW = 12
) (
  input  logic          wclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic [1:0]    def_sel,
  input  logic          ld,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          ser_en,
  input  logic          ser_in,
  output logic [AW-1:0] ae_offset,
  output logic [AW-1:0] af_offset
);
  import ofs_pkg::*;

  localparam int NBITS = 2 * AW;
  localparam int CW    = $clog2(NBITS);
  localparam logic [CW-1:0] LAST_POS = CW'(NBITS - 1);

  // Both offsets in one vector: almost-empty in the low half.
  logic [NBITS-1:0] pair_q;
  logic             par_mode_q;
  ofs_tgt_e         wtgt_q;
  logic [CW-1:0]    bitpos_q;
  logic [AW-1:0]    dflt_v;

  logic par_hit, ser_hit;

  assign dflt_v  = AW'(default_offset({ld, def_sel}));
  assign par_hit = par_mode_q  && wr_en  && ld;
  assign ser_hit = !par_mode_q && ser_en && ld;

  always_ff @(posedge wclk) begin
    if (mrst) begin
      par_mode_q <= ld;
      pair_q     <= {dflt_v, dflt_v};
      wtgt_q     <= TGT_AE;
      bitpos_q   <= '0;
    end else if (prst) begin
      wtgt_q     <= TGT_AE;
      bitpos_q   <= '0;
    end else if (par_hit) begin
      if (wtgt_q == TGT_AE) pair_q[AW-1:0]     <= wr_data;
      else                  pair_q[NBITS-1:AW] <= wr_data;
      wtgt_q <= next_tgt(wtgt_q);
    end else if (ser_hit) begin
      pair_q[bitpos_q] <= ser_in;
      bitpos_q <= (bitpos_q == LAST_POS) ? '0 : bitpos_q + 1'b1;
    end
  end

  assign ae_offset = pair_q[AW-1:0];
  assign af_offset = pair_q[NBITS-1:AW];

  AST_MODE_FIXED: assert property (@(posedge wclk) disable iff (mrst)
    1'b1 |=> $stable(par_mode_q));  // R2

  AST_IDLE_KEEPS: assert property (@(posedge wclk) disable iff (mrst)
    !(ld && (par_mode_q ? wr_en : ser_en)) |=> $stable(pair_q));  // R2

  AST_PRST_KEEPS: assert property (@(posedge wclk) disable iff (mrst)
    prst |=> ($stable(pair_q) && $stable(par_mode_q)));  // R9

  AST_PAR_FLIP: assert property (@(posedge wclk) disable iff (mrst)
    (!prst && par_mode_q && wr_en && ld) |=> (wtgt_q != $past(wtgt_q)));  // R3

  AST_POS_RANGE: assert property (@(posedge wclk) disable iff (mrst)
    bitpos_q <= LAST_POS);  // R4

endmodule

// File: rtl/ofs_read_side.sv
`timescale 1ns/1ps
module ofs_read_side #(
  parameter int AW = 12
) (
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          ld,
  input  logic          rd_en,
  input  logic [AW-1:0] ae_offset,
  input  logic [AW-1:0] af_offset,
  output logic [AW-1:0] rd_data,
  output logic          rd_valid
);
  import ofs_pkg::*;

  ofs_tgt_e rtgt_q;
  logic     rd_hit;

  assign rd_hit = rd_en && ld;

  always_ff @(posedge rclk) begin
    if (mrst) begin
      rtgt_q   <= TGT_AE;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (prst) begin
        rtgt_q <= TGT_AE;
      end else if (rd_hit) begin
        rd_data  <= (rtgt_q == TGT_AE) ? ae_offset : af_offset;
        rd_valid <= 1'b1;
        rtgt_q   <= next_tgt(rtgt_q);
      end
    end
  end

  AST_RD_PULSE: assert property (@(posedge rclk) disable iff (mrst)
    (rd_en && ld && !prst) |=> rd_valid);  // R5

  AST_RD_QUIET: assert property (@(posedge rclk) disable iff (mrst)
    !(rd_en && ld) |=> !rd_valid);  // R5

  AST_RD_HOLD: assert property (@(posedge rclk) disable iff (mrst)
    !rd_valid |-> $stable(rd_data));  // R5

endmodule

// File: rtl/flag_offset_regs.sv
`timescale 1ns/1ps
module flag_offset_regs #(
  parameter int AW = 12
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic [1:0]    def_sel,
  input  logic          ld,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic          rd_en,
  output logic [AW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] ae_offset,
  output logic [AW-1:0] af_offset
);

  ofs_load_side #(.AW(AW)) u_load (
    .wclk      (wclk),
    .mrst      (mrst),
    .prst      (prst),
    .def_sel   (def_sel),
    .ld        (ld),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ser_en    (ser_en),
    .ser_in    (ser_in),
    .ae_offset (ae_offset),
    .af_offset (af_offset)
  );

  ofs_read_side #(.AW(AW)) u_read (
    .rclk      (rclk),
    .mrst      (mrst),
    .prst      (prst),
    .ld        (ld),
    .rd_en     (rd_en),
    .ae_offset (ae_offset),
    .af_offset (af_offset),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  AST_RST_QUIET: assert property (@(posedge rclk)
    $past(mrst) |-> !rd_valid);  // R8

endmodule

// File: tb/sim_flag_offset_regs.sv
`timescale 1ns/1ps
module sim_flag_offset_regs;
  localparam int AW = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          mrst = 1'b1, prst = 1'b0, ld = 1'b0;
  logic [1:0]    def_sel = 2'd0;
  logic          wr_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_data = '0;
  logic [AW-1:0] rd_data, ae_offset, af_offset;
  logic          rd_valid;

  int n_chk = 0;
  int n_bad = 0;

  flag_offset_regs #(.AW(AW)) u0 (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .def_sel(def_sel),
    .ld(ld), .wr_en(wr_en), .wr_data(wr_data), .ser_en(ser_en),
    .ser_in(ser_in), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .ae_offset(ae_offset), .af_offset(af_offset)
  );

  function automatic logic [AW-1:0] dflt(input int k);
    return AW'((1 << (k + 3)) - 1);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic master_reset(input logic l, input logic [1:0] s);
    mrst = 1'b1; ld = l; def_sel = s;
    repeat (2) @(negedge clk);
    mrst = 1'b0; ld = 1'b0;
  endtask

  task automatic pwrite(input logic [AW-1:0] v);
    wr_data = v; wr_en = 1'b1; ld = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ld = 1'b0;
  endtask

  task automatic sshift(input logic b);
    ser_in = b; ser_en = 1'b1; ld = 1'b1;
    @(negedge clk);
    ser_en = 1'b0; ld = 1'b0;
  endtask

  task automatic sload(input logic [AW-1:0] v);
    for (int i = 0; i < AW; i++) sshift(v[i]);
  endtask

  task automatic rd_check(input logic [AW-1:0] exp, input string req);
    rd_en = 1'b1; ld = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; ld = 1'b0;
    chk(req, "rd_valid", 32'(rd_valid), 32'd1);
    chk(req, "rd_data", 32'(rd_data), 32'(exp));
  endtask

  task automatic t_defaults();
    for (int k = 0; k < 8; k++) begin
      logic [2:0] kk;
      kk = 3'(k);
      master_reset(kk[2], kk[1:0]);
      chk("R1", "default ae", 32'(ae_offset), 32'(dflt(k)));
      chk("R1", "default af", 32'(af_offset), 32'(dflt(k)));
    end
  endtask

  task automatic t_reset_ignores();
    mrst = 1'b1; ld = 1'b1; def_sel = 2'd2;
    wr_en = 1'b1; wr_data = 12'h123; ser_en = 1'b1; rd_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "rd_valid in reset", 32'(rd_valid), 32'd0);
    mrst = 1'b0; ld = 1'b0; wr_en = 1'b0; ser_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    chk("R8", "ae after reset with strobes", 32'(ae_offset), 32'(dflt(6)));
    chk("R8", "rd_valid after reset", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_parallel();
    master_reset(1'b1, 2'd1);
    pwrite(12'h100);
    chk("R3", "first write to ae", 32'(ae_offset), 32'h100);
    chk("R7", "af untouched", 32'(af_offset), 32'(dflt(5)));
    pwrite(12'hABC);
    chk("R3", "second write to af", 32'(af_offset), 32'hABC);
    chk("R7", "ae untouched", 32'(ae_offset), 32'h100);
    pwrite(12'hFFF);
    chk("R3", "third write back to ae", 32'(ae_offset), 32'hFFF);
    wr_data = 12'h777; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3", "wr_en without ld ae", 32'(ae_offset), 32'hFFF);
    chk("R3", "wr_en without ld af", 32'(af_offset), 32'hABC);
    for (int i = 0; i < 3; i++) sshift(1'b0);
    chk("R2", "serial ignored ae", 32'(ae_offset), 32'hFFF);
    chk("R2", "serial ignored af", 32'(af_offset), 32'hABC);
    rd_check(12'hFFF, "R5");
    rd_check(12'hABC, "R5");
    rd_check(12'hFFF, "R5");
    @(negedge clk);
    chk("R5", "rd_valid drops", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_partial();
    // write target and read target both point at af now
    prst = 1'b1; wr_data = 12'h0AA; wr_en = 1'b1; ld = 1'b1;
    @(negedge clk);
    prst = 1'b0; wr_en = 1'b0; ld = 1'b0;
    chk("R9", "load during prst ae", 32'(ae_offset), 32'hFFF);
    chk("R6", "offsets kept af", 32'(af_offset), 32'hABC);
    pwrite(12'h321);
    chk("R6", "write restarts at ae", 32'(ae_offset), 32'h321);
    chk("R6", "af still kept", 32'(af_offset), 32'hABC);
    rd_check(12'h321, "R6");
  endtask

  task automatic t_serial();
    master_reset(1'b0, 2'd3);
    chk("R1", "serial-mode default ae", 32'(ae_offset), 32'(dflt(3)));
    sload(12'h5A3);
    sload(12'hC3F);
    chk("R4", "serial ae", 32'(ae_offset), 32'h5A3);
    chk("R4", "serial af", 32'(af_offset), 32'hC3F);
    for (int i = 0; i < 3; i++) sshift(1'b1);
    chk("R4", "wrap in place ae", 32'(ae_offset), 32'h5A7);
    prst = 1'b1;
    @(negedge clk);
    prst = 1'b0;
    sload(12'h00F);
    chk("R6", "serial restarts at ae bit0", 32'(ae_offset), 32'h00F);
    sload(12'h800);
    chk("R4", "serial af after restart", 32'(af_offset), 32'h800);
    pwrite(12'h111);
    chk("R2", "parallel ignored in serial", 32'(ae_offset), 32'h00F);
    rd_check(12'h00F, "R5");
    rd_check(12'h800, "R5");
    sshift(1'b0);
    chk("R4", "after wrap bit0 of ae", 32'(ae_offset), 32'h00E);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_defaults();
    t_reset_ignores();
    t_parallel();
    t_partial();
    t_serial();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule